// File: doc/BRIEF.md
# Free-Hole Allocation Policy Engine

This block keeps a small table of free memory regions ("holes"). Each entry holds a start address and a length. A requester asks for `n` units and picks one of three placement policies at run time. The engine then walks the table one entry per clock cycle and picks a hole. It returns that hole's start address and carves the granted units off the front of the hole. If no single hole can hold the request, it reports failure.

One scanning engine serves all three policies:

- **First-fit** ends the walk at the first qualifying entry.
- **Best-fit** and **worst-fit** always walk the whole table and keep a running candidate.

Returned regions come back through a separate free port. The free port drops each returned region into the lowest unused table slot and flags an overflow when no slot is free. Adjacent holes are never merged, and nothing is ever moved.

Top module: `hole_alloc`

## Requirements
- R1: After reset, `req_ready` is high whenever no scan is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. A nonzero request drives `req_ready` low from the next cycle until its response. `rsp_valid` is a one-cycle pulse, and `rsp_ok` is never high without `rsp_valid`.
- R2: Policy codes are 0 for first-fit, 1 for best-fit and 2 for worst-fit. Code 3 behaves as first-fit.
- R3: First-fit grants the lowest-index valid entry whose size is at least `n`. When that entry has index k, `rsp_valid` rises k+1 cycles after the accepting edge. When nothing fits, it rises after N cycles.
- R4: Best-fit grants the valid entry with the smallest size that is at least `n`. On equal sizes the lower index wins. The response comes N cycles after acceptance.
- R5: Worst-fit grants the valid entry with the largest size, provided that size is at least `n`. On equal sizes the lower index wins. The response comes N cycles after acceptance.
- R6: When no single valid entry holds `n` units, the response has `rsp_ok`=0 and `rsp_addr`=0, and the table is left unchanged. This holds even when the sizes of all holes add up to more than `n`.
- R7: A grant returns the entry's start address. It then raises that start by `n` and lowers the entry's size by `n`. When the size reaches zero, the entry becomes invalid.
- R8: A request of size zero is rejected on its accepting edge. `rsp_valid`=1 and `rsp_ok`=0 are visible right after that edge, no scan starts, and the table is unchanged.
- R9: A free of nonzero size is written into the lowest-index invalid entry. When all entries are valid, `free_overflow` pulses for one cycle after that edge and the table is unchanged.
- R10: A free of size zero is ignored. No entry is written and `free_overflow` stays low.
- R11: During and right after reset, all entries are invalid, `req_ready`=1, `rsp_valid`=0 and `free_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_size | input | SW | Units requested |
| req_policy | input | 2 | 0 first-fit, 1 best-fit, 2 worst-fit, 3 first-fit |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request granted |
| rsp_addr | output | AW | Granted start address, 0 on failure |
| free_valid | input | 1 | Region being returned |
| free_addr | input | AW | Start of returned region |
| free_size | input | SW | Length of returned region |
| free_overflow | output | 1 | Returned region dropped because the table was full |

## Verification
The bench loads a fixed set of four holes that includes two of equal size. It then sweeps every request size from zero past the largest hole under all four policy codes.

- Small sizes tell first-fit apart from best-fit, and middle sizes tell best-fit apart from worst-fit.
- The tied pair exposes the tie rule.
- Sizes above the largest hole but below the total free space expose external fragmentation.

A second request after each sweep point confirms that the hole was trimmed. Directed sequences drain a hole to zero, fill the table to overflow and return zero-length regions. A long pseudo-random mix of frees and requests is then checked against an arithmetic model for address, result and response latency.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;
  typedef enum logic [1:0] {
    POL_FIRST = 2'd0,
    POL_BEST  = 2'd1,
    POL_WORST = 2'd2,
    POL_ALT   = 2'd3
  } policy_e;
endpackage

// File: rtl/hole_table.sv
// Hole storage: in-place trimming on grant, lowest-free-slot insertion on release.
module hole_table #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 8,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grant_en,
  input  logic [IW-1:0]          grant_idx,
  input  logic [SW-1:0]          grant_amt,
  input  logic                   free_valid,
  input  logic [AW-1:0]          free_addr,
  input  logic [SW-1:0]          free_size,
  output logic [N-1:0]           ent_vld,
  output logic [N-1:0][AW-1:0]   ent_addr,
  output logic [N-1:0][SW-1:0]   ent_size,
  output logic                   free_overflow
);
  logic [N-1:0]         vld_q, vld_d;
  logic [N-1:0][AW-1:0] addr_q, addr_d;
  logic [N-1:0][SW-1:0] size_q, size_d;
  logic                 ovf_q, ovf_d;
  logic                 slot_found;
  logic [IW-1:0]        slot_idx;
  logic                 tbl_en;

  // lowest-index invalid slot
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        slot_found = 1'b1;
        slot_idx   = IW'(i);
      end
    end
  end

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    size_d = size_q;
    ovf_d  = 1'b0;
    if (grant_en) begin
      addr_d[grant_idx] = addr_q[grant_idx] + AW'(grant_amt);
      size_d[grant_idx] = size_q[grant_idx] - grant_amt;
      if (size_q[grant_idx] == grant_amt) vld_d[grant_idx] = 1'b0;
    end
    // a granted entry is valid, so it never collides with the free slot
    if (free_valid && (free_size != '0)) begin
      if (slot_found) begin
        vld_d[slot_idx]  = 1'b1;
        addr_d[slot_idx] = free_addr;
        size_d[slot_idx] = free_size;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  assign tbl_en = grant_en | free_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else if (tbl_en) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      size_q <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ent_vld       = vld_q;
  assign ent_addr      = addr_q;
  assign ent_size      = size_q;
  assign free_overflow = ovf_q;
endmodule

// File: rtl/fit_scanner.sv
// Sequential one-entry-per-cycle scan shared by all placement policies.
module fit_scanner
  import hole_alloc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 8,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SW-1:0]          req_size,
  input  logic [1:0]             req_policy,
  output logic                   req_ready,
  input  logic [N-1:0]           ent_vld,
  input  logic [N-1:0][AW-1:0]   ent_addr,
  input  logic [N-1:0][SW-1:0]   ent_size,
  output logic                   rsp_valid,
  output logic                   rsp_ok,
  output logic [AW-1:0]          rsp_addr,
  output logic                   grant_en,
  output logic [IW-1:0]          grant_idx,
  output logic [SW-1:0]          grant_amt
);
  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [SW-1:0] need_q, need_d;
  policy_e       pol_q, pol_d;
  logic          have_q, have_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic [SW-1:0] bsize_q, bsize_d;
  logic          rv_q, rv_d, rok_q, rok_d;
  logic [AW-1:0] raddr_q, raddr_d;

  logic          first_mode, cur_hit, better, take, last, finish, accept;
  logic          win_have;
  logic [IW-1:0] win_idx;
  logic          scan_en;

  assign first_mode = (pol_q == POL_FIRST) || (pol_q == POL_ALT);
  assign cur_hit    = ent_vld[idx_q] && (ent_size[idx_q] >= need_q);
  assign better     = (pol_q == POL_BEST) ? (ent_size[idx_q] < bsize_q)
                                          : (ent_size[idx_q] > bsize_q);
  assign take       = cur_hit && (first_mode || !have_q || better);
  assign last       = (idx_q == IW'(N - 1));
  assign finish     = busy_q && ((first_mode && cur_hit) || last);
  assign win_have   = have_q || take;
  assign win_idx    = take ? idx_q : bidx_q;
  assign accept     = req_valid && !busy_q;

  assign grant_en  = finish && win_have;
  assign grant_idx = win_idx;
  assign grant_amt = need_q;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    need_d  = need_q;
    pol_d   = pol_q;
    have_d  = have_q;
    bidx_d  = bidx_q;
    bsize_d = bsize_q;
    rv_d    = 1'b0;
    rok_d   = 1'b0;
    raddr_d = '0;
    if (accept) begin
      if (req_size == '0) begin
        rv_d = 1'b1;
      end else begin
        busy_d  = 1'b1;
        idx_d   = '0;
        need_d  = req_size;
        pol_d   = policy_e'(req_policy);
        have_d  = 1'b0;
        bidx_d  = '0;
        bsize_d = '0;
      end
    end else if (busy_q) begin
      if (take) begin
        have_d  = 1'b1;
        bidx_d  = idx_q;
        bsize_d = ent_size[idx_q];
      end
      if (finish) begin
        busy_d  = 1'b0;
        rv_d    = 1'b1;
        rok_d   = win_have;
        raddr_d = win_have ? ent_addr[win_idx] : '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  assign scan_en = accept | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      need_q  <= '0;
      pol_q   <= POL_FIRST;
      have_q  <= 1'b0;
      bidx_q  <= '0;
      bsize_q <= '0;
    end else if (scan_en) begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      need_q  <= need_d;
      pol_q   <= pol_d;
      have_q  <= have_d;
      bidx_q  <= bidx_d;
      bsize_q <= bsize_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rok_q   <= 1'b0;
      raddr_q <= '0;
    end else begin
      rv_q    <= rv_d;
      rok_q   <= rok_d;
      raddr_q <= raddr_d;
    end
  end

  assign req_ready = !busy_q;
  assign rsp_valid = rv_q;
  assign rsp_ok    = rok_q;
  assign rsp_addr  = raddr_q;
endmodule

// File: rtl/hole_alloc.sv
module hole_alloc #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_size,
  input  logic [1:0]    req_policy,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [AW-1:0] rsp_addr,
  input  logic          free_valid,
  input  logic [AW-1:0] free_addr,
  input  logic [SW-1:0] free_size,
  output logic          free_overflow
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]         ent_vld;
  logic [N-1:0][AW-1:0] ent_addr;
  logic [N-1:0][SW-1:0] ent_size;
  logic                 grant_en;
  logic [IW-1:0]        grant_idx;
  logic [SW-1:0]        grant_amt;

  fit_scanner #(.N(N), .AW(AW), .SW(SW), .IW(IW)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .req_policy (req_policy),
    .req_ready  (req_ready),
    .ent_vld    (ent_vld),
    .ent_addr   (ent_addr),
    .ent_size   (ent_size),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_addr   (rsp_addr),
    .grant_en   (grant_en),
    .grant_idx  (grant_idx),
    .grant_amt  (grant_amt)
  );

  hole_table #(.N(N), .AW(AW), .SW(SW), .IW(IW)) u_tbl (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_en      (grant_en),
    .grant_idx     (grant_idx),
    .grant_amt     (grant_amt),
    .free_valid    (free_valid),
    .free_addr     (free_addr),
    .free_size     (free_size),
    .ent_vld       (ent_vld),
    .ent_addr      (ent_addr),
    .ent_size      (ent_size),
    .free_overflow (free_overflow)
  );
endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_size,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          free_valid,
  input logic [SW-1:0] free_size,
  input logic          free_overflow
);
  assert_ok_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_valid);

  assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size != '0)) |=> !req_ready);

  assert_zero_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size == '0)) |=> (rsp_valid && !rsp_ok));

  // R3: a grant always comes out of a scan, never from an idle engine
  assert_grant_from_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> $past(!req_ready));

  assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_overflow |-> $past(free_valid && (free_size != '0)));

  assert_zero_free_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && (free_size == '0)) |=> !free_overflow);
endmodule

bind hole_alloc hole_alloc_chk #(.SW(SW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_size      (req_size),
  .rsp_valid     (rsp_valid),
  .rsp_ok        (rsp_ok),
  .free_valid    (free_valid),
  .free_size     (free_size),
  .free_overflow (free_overflow)
);

// File: tb/hole_alloc_test.sv
`timescale 1ns/1ps
module hole_alloc_test;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_size;
  logic [1:0] req_policy;
  logic       rsp_valid;
  logic       rsp_ok;
  logic [7:0] rsp_addr;
  logic       free_valid;
  logic [7:0] free_addr;
  logic [7:0] free_size;
  logic       free_overflow;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic       mv[N];
  logic [7:0] ma[N];
  logic [7:0] ms[N];

  always #2.5 clk = ~clk;

  hole_alloc uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_policy(req_policy),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
    .free_valid(free_valid), .free_addr(free_addr), .free_size(free_size),
    .free_overflow(free_overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_size = 0; req_policy = 0;
    free_valid = 0; free_addr = 0; free_size = 0;
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = 0; ms[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R11 ready in reset", req_ready, 1);
    chk("R11 rsp_valid in reset", rsp_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_free(input logic [7:0] a, input logic [7:0] s);
    int slot;
    int exp_ovf;
    slot = -1;
    exp_ovf = 0;
    @(negedge clk);
    free_valid = 1; free_addr = a; free_size = s;
    if (s != 0) begin
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
      if (slot >= 0) begin mv[slot] = 1; ma[slot] = a; ms[slot] = s; end
      else exp_ovf = 1;
    end
    @(posedge clk); #1;
    if (s == 0) chk("R10 zero free no overflow", free_overflow, 0);
    else        chk("R9 overflow flag", free_overflow, exp_ovf);
    @(negedge clk);
    free_valid = 0;
  endtask

  task automatic do_req(input logic [7:0] n, input logic [1:0] pol);
    int sel;
    int lat;
    int exp_lat;
    bit first;
    sel = -1;
    first = (pol == 2'd0) || (pol == 2'd3);
    if (n != 0) begin
      for (int i = 0; i < N; i++) begin
        if (mv[i] && ms[i] >= n) begin
          if (sel < 0) sel = i;
          else if (pol == 2'd1 && ms[i] < ms[sel]) sel = i;
          else if (pol == 2'd2 && ms[i] > ms[sel]) sel = i;
        end
      end
    end
    if (n == 0) exp_lat = 0;
    else if (first) exp_lat = (sel >= 0) ? sel + 1 : N;
    else exp_lat = N;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_size = n; req_policy = pol;
    @(posedge clk); #1;
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(posedge clk); #1;
      lat++;
    end
    if (n == 0) begin
      chk("R8 zero size rejected", rsp_ok, 0);
      chk("R8 zero size latency", lat, 0);
    end else begin
      chk(pol == 2'd1 ? "R4 best-fit ok" : pol == 2'd2 ? "R5 worst-fit ok" : "R3 first-fit ok",
          rsp_ok, sel >= 0);
      chk("R7 granted address / R6 zero on fail", rsp_addr, sel >= 0 ? ma[sel] : 0);
      chk(first ? "R3 scan latency" : "R4 R5 scan latency", lat, exp_lat);
      if (sel >= 0) begin
        ma[sel] = ma[sel] + n;
        ms[sel] = ms[sel] - n;
        if (ms[sel] == 0) mv[sel] = 0;
      end
    end
    @(posedge clk); #1;
    chk("R1 response is a pulse", rsp_valid, 0);
    chk("R1 ready after response", req_ready, 1);
  endtask

  task automatic load_std();
    do_free(8'h10, 8'd5);
    do_free(8'h40, 8'd9);
    do_free(8'h80, 8'd3);
    do_free(8'hC0, 8'd9);
  endtask

  initial begin
    int seed;
    do_reset();
    #1;
    chk("R11 overflow after reset", free_overflow, 0);
    chk("R11 no response after reset", rsp_valid, 0);

    // R2 R3 R4 R5 R6: sweep sizes under every policy code
    for (int pol = 0; pol < 4; pol++) begin
      for (int n = 0; n <= 12; n++) begin
        do_reset();
        load_std();
        do_req(8'(n), 2'(pol));
        do_req(8'd3, 2'(pol));   // R7 trimmed hole visible to the next pick
      end
    end

    // R7 drain a hole to zero, R9 freed region lands in lowest invalid slot
    do_reset();
    do_free(8'h20, 8'd4);
    do_req(8'd4, 2'd0);
    do_req(8'd1, 2'd0);
    do_free(8'h30, 8'd2);
    do_free(8'h50, 8'd6);
    do_req(8'd2, 2'd0);

    // R9 overflow and R10 zero free into a full table
    do_reset();
    do_free(8'h00, 8'd0);
    load_std();
    do_free(8'hE0, 8'd7);
    do_free(8'hF0, 8'd0);
    do_req(8'd9, 2'd2);
    do_req(8'd9, 2'd2);
    do_req(8'd9, 2'd2);

    // mixed pseudo-random traffic checked against the model
    do_reset();
    seed = 13;
    for (int k = 0; k < 400; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      if (((seed >> 8) % 3) == 0)
        do_free(8'(seed >> 12), 8'((seed >> 20) % 8));
      else
        do_req(8'((seed >> 12) % 11), 2'((seed >> 18) % 4));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule